// File: doc/BRIEF.md
# Immediate-Extension Prefix Unit

This decode-stage helper lets a small 32-bit processor that runs several hardware tasks build a full-width immediate from two instructions. A dedicated prefix instruction carries a 23-bit payload. The unit keeps that payload in a hidden slot that belongs to the issuing task, and it writes no visible register or flag. The next issued instruction from the same task consumes the slot. If that instruction takes an immediate, its operand becomes the payload in the upper bits joined with the instruction's own 9-bit source field in the lower bits. After use, the slot is cleared.

Each task has its own slot, so tasks that interleave on alternate cycles cannot pick up each other's upper bits. A load whose 9-bit immediate is zero, issued right after a prefix, is marked as addressing memory through the hidden value. This makes any location reachable in two instructions.

The decoded instruction arrives as a stream qualified by `issue_valid`. There is no ready signal and no back-pressure. The unit accepts every valid cycle, and its outputs are combinational on the current instruction. The outputs are meaningful only while `issue_valid` is high. Slot state changes at the clock edge that ends a valid cycle.

Top module: `imm_prefix_unit`

## Requirements
- R1: A synchronous active-high `rst` empties every task slot. After reset, no instruction is extended until a new prefix is issued, even if a prefix was pending before the reset.
- R2: On a cycle that carries a prefix (`issue_prefix`=1), `ext_active` and `ext_addr_hidden` are 0 and `ext_operand` is the 9-bit `issue_imm` zero-extended.
- R3: A valid instruction with `issue_uses_imm`=1 from a task whose slot is pending drives `ext_active`=1 and `ext_operand` = {payload[22:0], issue_imm[8:0]}, with the payload in bits 31:9.
- R4: A slot is consumed by its task's next valid non-prefix instruction. A later instruction from that task sees no extension.
- R5: A pending slot is neither used nor consumed by instructions from other tasks, and each task receives its own payload.
- R6: If the next instruction of the task has `issue_uses_imm`=0, the prefix is discarded silently: `ext_active` stays 0 and the following instruction is not extended.
- R7: Two prefixes in a row from one task: the second payload replaces the first, and only the instruction after the second is extended.
- R8: A cycle with `issue_valid`=0 neither loads nor consumes a slot, and it drives `ext_active`=0.
- R9: `ext_addr_hidden`=1 exactly when an extended instruction has `issue_is_load`=1 and `issue_imm`=0. In that case `ext_operand` = {payload, 9'b0}. A load with a nonzero immediate is extended but `ext_addr_hidden`=0.
- R10: With no prefix pending, `ext_operand` is `issue_imm` zero-extended and `ext_active` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Decoded instruction is valid this cycle |
| issue_task | input | 2 | Hardware task that issued the instruction |
| issue_prefix | input | 1 | Instruction is the prefix |
| issue_payload | input | 23 | Payload carried by a prefix |
| issue_uses_imm | input | 1 | Instruction takes an immediate source |
| issue_is_load | input | 1 | Instruction is a memory load |
| issue_imm | input | 9 | Instruction's own source immediate |
| ext_operand | output | 32 | Extended or zero-extended operand |
| ext_active | output | 1 | Operand is extended by a prefix |
| ext_addr_hidden | output | 1 | Load uses the hidden value as its full address |

## Verification
The hardest case to reach is a pending slot that must survive activity from other tasks and squashed cycles, and then be consumed exactly once. To produce it, the stimulus interleaves prefixes from two tasks, inserts traffic from a third task, and adds invalid cycles carrying prefix bits. It then checks each owner's extension and the empty slot on that owner's next instruction. Reset in the middle of a pending prefix, and back-to-back prefixes, are driven as separate directed sequences.

// File: rtl/imm_prefix_pkg.sv
package imm_prefix_pkg;
  localparam int DEF_TASKS   = 4;
  localparam int DEF_PAYLOAD = 23;
  localparam int DEF_IMM     = 9;
endpackage

// File: rtl/prefix_slot.sv
module prefix_slot #(
  parameter int PAYLOAD_W = 23
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load_en,
  input  logic                 use_en,
  input  logic [PAYLOAD_W-1:0] payload_in,
  output logic                 pend,
  output logic [PAYLOAD_W-1:0] payload_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend      <= 1'b0;
      payload_q <= '0;
    end else if (load_en) begin
      pend      <= 1'b1;
      payload_q <= payload_in;
    end else if (use_en) begin
      pend      <= 1'b0;
      payload_q <= '0;
    end
  end

  assert_clear_after_use_R4: assert property (@(posedge clk) disable iff (rst)
    (use_en && !load_en) |=> (!pend && payload_q == '0));
  assert_empty_is_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !pend |-> payload_q == '0);
  assert_overwrite_R7: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (pend && payload_q == $past(payload_in)));
endmodule

// File: rtl/prefix_select.sv
module prefix_select #(
  parameter int NUM_TASKS = 4,
  parameter int PAYLOAD_W = 23,
  parameter int IMM_W     = 9,
  localparam int TID_W    = $clog2(NUM_TASKS),
  localparam int OPER_W   = PAYLOAD_W + IMM_W
) (
  input  logic                 valid,
  input  logic [TID_W-1:0]     task_id,
  input  logic                 is_prefix,
  input  logic                 uses_imm,
  input  logic                 is_load,
  input  logic [IMM_W-1:0]     imm,
  input  logic [NUM_TASKS-1:0] pend_vec,
  input  logic [PAYLOAD_W-1:0] payload_arr [NUM_TASKS],
  output logic [OPER_W-1:0]    operand,
  output logic                 active,
  output logic                 addr_hidden
);
  logic                 hit;
  logic [PAYLOAD_W-1:0] hi_bits;

  always_comb begin
    hit         = valid && !is_prefix && pend_vec[task_id];
    hi_bits     = payload_arr[task_id];
    active      = hit && uses_imm;
    addr_hidden = active && is_load && (imm == '0);
    operand     = active ? {hi_bits, imm} : {{PAYLOAD_W{1'b0}}, imm};
  end
endmodule

// File: rtl/imm_prefix_unit.sv
module imm_prefix_unit
  import imm_prefix_pkg::*;
#(
  parameter int NUM_TASKS = DEF_TASKS,
  parameter int PAYLOAD_W = DEF_PAYLOAD,
  parameter int IMM_W     = DEF_IMM,
  localparam int TID_W    = $clog2(NUM_TASKS),
  localparam int OPER_W   = PAYLOAD_W + IMM_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 issue_valid,
  input  logic [TID_W-1:0]     issue_task,
  input  logic                 issue_prefix,
  input  logic [PAYLOAD_W-1:0] issue_payload,
  input  logic                 issue_uses_imm,
  input  logic                 issue_is_load,
  input  logic [IMM_W-1:0]     issue_imm,
  output logic [OPER_W-1:0]    ext_operand,
  output logic                 ext_active,
  output logic                 ext_addr_hidden
);
  logic [NUM_TASKS-1:0] pend_vec;
  logic [PAYLOAD_W-1:0] payload_arr [NUM_TASKS];

  for (genvar t = 0; t < NUM_TASKS; t++) begin : g_slot
    logic mine;
    assign mine = issue_valid && (issue_task == TID_W'(t));
    prefix_slot #(.PAYLOAD_W(PAYLOAD_W)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .load_en   (mine && issue_prefix),
      .use_en    (mine && !issue_prefix),
      .payload_in(issue_payload),
      .pend      (pend_vec[t]),
      .payload_q (payload_arr[t])
    );
    assert_other_task_keeps_R5: assert property (@(posedge clk) disable iff (rst)
      (!mine && pend_vec[t]) |=> (pend_vec[t] && $stable(payload_arr[t])));
  end

  prefix_select #(
    .NUM_TASKS(NUM_TASKS), .PAYLOAD_W(PAYLOAD_W), .IMM_W(IMM_W)
  ) u_select (
    .valid      (issue_valid),
    .task_id    (issue_task),
    .is_prefix  (issue_prefix),
    .uses_imm   (issue_uses_imm),
    .is_load    (issue_is_load),
    .imm        (issue_imm),
    .pend_vec   (pend_vec),
    .payload_arr(payload_arr),
    .operand    (ext_operand),
    .active     (ext_active),
    .addr_hidden(ext_addr_hidden)
  );

  assert_active_needs_instr_R8: assert property (@(posedge clk) disable iff (rst)
    ext_active |-> (issue_valid && !issue_prefix && issue_uses_imm));
  assert_addr_needs_ext_R9: assert property (@(posedge clk) disable iff (rst)
    ext_addr_hidden |-> (ext_active && issue_is_load));
  assert_plain_operand_R10: assert property (@(posedge clk) disable iff (rst)
    !ext_active |-> (ext_operand[OPER_W-1:IMM_W] == '0));
endmodule

// File: tb/imm_prefix_unit_bench.sv
module imm_prefix_unit_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        v, pf, ui, ld;
  logic [1:0]  tk;
  logic [22:0] pl;
  logic [8:0]  im;
  logic [31:0] op;
  logic        act, ah;
  int          n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  imm_prefix_unit u_imm_prefix_unit (
    .clk(clk), .rst(rst), .issue_valid(v), .issue_task(tk), .issue_prefix(pf),
    .issue_payload(pl), .issue_uses_imm(ui), .issue_is_load(ld), .issue_imm(im),
    .ext_operand(op), .ext_active(act), .ext_addr_hidden(ah)
  );

  task automatic check(string req, logic [33:0] exp);
    n_run++;
    if ({ah, act, op} !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, {ah, act, op}, exp);
    end
  endtask

  // drive one cycle at the falling edge, sample mid-cycle
  task automatic cyc(logic iv, logic [1:0] it, logic ipf, logic [22:0] ipl,
                     logic iui, logic ild, logic [8:0] iim);
    v = iv; tk = it; pf = ipf; pl = ipl; ui = iui; ld = ild; im = iim;
    #5;
  endtask

  task automatic step; @(negedge clk); endtask

  function automatic logic [33:0] plain(logic [8:0] i);
    return {2'b00, 23'd0, i};
  endfunction
  function automatic logic [33:0] ext(logic [22:0] p, logic [8:0] i, logic hid);
    return {hid, 1'b1, p, i};
  endfunction

  task automatic t_reset;
    rst = 1'b1; cyc(1'b0, 2'd0, 1'b0, 23'd0, 1'b0, 1'b0, 9'd0);
    step(); step(); rst = 1'b0;
    cyc(1'b1, 2'd0, 1'b1, 23'h7ABCDE, 1'b0, 1'b0, 9'd0); step();
    rst = 1'b1; cyc(1'b0, 2'd0, 1'b0, 23'd0, 1'b0, 1'b0, 9'd0); step();
    rst = 1'b0;
    for (int t = 0; t < 4; t++) begin
      cyc(1'b1, 2'(t), 1'b0, 23'd0, 1'b1, 1'b0, 9'h055);
      check("R1 slot empty after reset", plain(9'h055)); step();
    end
  endtask

  task automatic t_basic;
    cyc(1'b1, 2'd1, 1'b0, 23'd0, 1'b1, 1'b0, 9'h1FF);
    check("R10 no prefix pending", plain(9'h1FF)); step();
    cyc(1'b1, 2'd1, 1'b1, 23'h123456, 1'b1, 1'b0, 9'h0A5);
    check("R2 prefix cycle not extended", plain(9'h0A5)); step();
    cyc(1'b1, 2'd1, 1'b0, 23'd0, 1'b1, 1'b0, 9'h1C3);
    check("R3 extended operand", ext(23'h123456, 9'h1C3, 1'b0)); step();
    cyc(1'b1, 2'd1, 1'b0, 23'd0, 1'b1, 1'b0, 9'h1C3);
    check("R4 consumed once", plain(9'h1C3)); step();
  endtask

  task automatic t_interleave;
    cyc(1'b1, 2'd0, 1'b1, 23'h000001, 1'b0, 1'b0, 9'd0); step();
    cyc(1'b1, 2'd3, 1'b1, 23'h7FFFFF, 1'b0, 1'b0, 9'd0); step();
    cyc(1'b1, 2'd2, 1'b0, 23'd0, 1'b1, 1'b0, 9'h011);
    check("R5 other task unaffected", plain(9'h011)); step();
    cyc(1'b1, 2'd3, 1'b0, 23'd0, 1'b1, 1'b0, 9'h000);
    check("R5 task3 own payload", ext(23'h7FFFFF, 9'h000, 1'b0)); step();
    cyc(1'b1, 2'd0, 1'b0, 23'd0, 1'b1, 1'b0, 9'h100);
    check("R5 task0 own payload", ext(23'h000001, 9'h100, 1'b0)); step();
    cyc(1'b1, 2'd3, 1'b0, 23'd0, 1'b1, 1'b0, 9'h002);
    check("R4 task3 slot emptied", plain(9'h002)); step();
  endtask

  task automatic t_nonimm;
    cyc(1'b1, 2'd2, 1'b1, 23'h2AAAAA, 1'b0, 1'b0, 9'd0); step();
    cyc(1'b1, 2'd2, 1'b0, 23'd0, 1'b0, 1'b0, 9'h033);
    check("R6 non-imm instr not extended", plain(9'h033)); step();
    cyc(1'b1, 2'd2, 1'b0, 23'd0, 1'b1, 1'b0, 9'h044);
    check("R6 prefix discarded", plain(9'h044)); step();
  endtask

  task automatic t_double;
    cyc(1'b1, 2'd1, 1'b1, 23'h111111, 1'b0, 1'b0, 9'd0); step();
    cyc(1'b1, 2'd1, 1'b1, 23'h222222, 1'b1, 1'b0, 9'h077);
    check("R7 second prefix not extended", plain(9'h077)); step();
    cyc(1'b1, 2'd1, 1'b0, 23'd0, 1'b1, 1'b0, 9'h088);
    check("R7 second payload wins", ext(23'h222222, 9'h088, 1'b0)); step();
  endtask

  task automatic t_squash;
    cyc(1'b0, 2'd0, 1'b1, 23'h3CCCCC, 1'b0, 1'b0, 9'd0);
    check("R8 invalid prefix cycle", {2'b00, 32'h0}); step();
    cyc(1'b1, 2'd0, 1'b0, 23'd0, 1'b1, 1'b0, 9'h012);
    check("R8 squashed prefix not loaded", plain(9'h012)); step();
    cyc(1'b1, 2'd0, 1'b1, 23'h0F0F0F, 1'b0, 1'b0, 9'd0); step();
    cyc(1'b0, 2'd0, 1'b0, 23'd0, 1'b1, 1'b0, 9'h013);
    check("R8 squashed instr inactive", plain(9'h013)); step();
    cyc(1'b1, 2'd0, 1'b0, 23'd0, 1'b1, 1'b0, 9'h014);
    check("R8 prefix survives squash", ext(23'h0F0F0F, 9'h014, 1'b0)); step();
  endtask

  task automatic t_load;
    cyc(1'b1, 2'd3, 1'b1, 23'h5A5A5A, 1'b0, 1'b0, 9'd0); step();
    cyc(1'b1, 2'd3, 1'b0, 23'd0, 1'b1, 1'b1, 9'h000);
    check("R9 load uses hidden address", ext(23'h5A5A5A, 9'h000, 1'b1)); step();
    cyc(1'b1, 2'd3, 1'b1, 23'h000ABC, 1'b0, 1'b0, 9'd0); step();
    cyc(1'b1, 2'd3, 1'b0, 23'd0, 1'b1, 1'b1, 9'h004);
    check("R9 load nonzero imm", ext(23'h000ABC, 9'h004, 1'b0)); step();
    cyc(1'b1, 2'd3, 1'b0, 23'd0, 1'b1, 1'b1, 9'h000);
    check("R9 load without prefix", plain(9'h000)); step();
  endtask

  initial begin
    #4000000;
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_interleave();
    t_nonimm();
    t_double();
    t_squash();
    t_load();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule